// File: doc/BRIEF.md
# Byte-Length Stream Packetizer

The block turns a plain word source into one AXI4-Stream packet per command. A command carries a packet length in bytes. The block then pulls exactly ceil(length / bytes-per-word) words from the source and sends each one downstream as a beat. It marks the final beat with TLAST. On that beat the byte-keep mask covers only the bytes that belong to the packet, counted from byte 0.

Between packets the block keeps its downstream valid low and its source ready low, so no word is taken or offered outside a packet. A command with a length of zero is refused: the block raises a one-cycle error flag and sends no beats. The downstream port has one register stage, so its payload stays steady under back-pressure whatever the source does.

Top module: `stream_packetizer`

## Requirements
- R1: A command of length L > 0 produces exactly ceil(L / BYTES) downstream transfers, where a transfer is a cycle with both m_tvalid_o and m_tready_i high.
- R2: m_tlast_o is high on the final transfer of a packet and low on every other transfer.
- R3: On every transfer with m_tlast_o low, m_tkeep_o is all ones.
- R4: On the final transfer, m_tkeep_o has its low (L mod BYTES) bits set and the rest clear, or is all ones when L mod BYTES is 0. It is never all zeros (for BYTES = 4: 0001, 0011, 0111 or 1111).
- R5: The beats carry the source words unchanged and in the order the source handed them over. A source word is taken only on a cycle where both src_valid_i and src_ready_o are high.
- R6: While no packet is in progress, m_tvalid_o and src_ready_o are both low, whatever src_valid_i and m_tready_i do.
- R7: While m_tvalid_o is high and m_tready_i is low, m_tdata_o, m_tkeep_o and m_tlast_o hold their values and m_tvalid_o stays high in the next cycle.
- R8: A command with length 0 is accepted. err_o goes high for exactly the one cycle after it, no beat is sent, and the block is ready for a new command.
- R9: cmd_ready_o is high when no packet is in progress and low from the cycle after a non-zero command is accepted until the cycle after its final transfer.
- R10: Gaps in src_valid_i and downstream stalls change neither the beat count nor the content of a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Start command present |
| cmd_ready_o | output | 1 | Block is idle and takes a command |
| cmd_len_i | input | LEN_W | Packet length in bytes |
| err_o | output | 1 | One-cycle flag after a zero-length command |
| src_valid_i | input | 1 | Source word present |
| src_ready_o | output | 1 | Block takes the source word |
| src_data_i | input | DATA_W | Source word |
| m_tvalid_o | output | 1 | Stream beat valid |
| m_tready_i | input | 1 | Stream sink ready |
| m_tdata_o | output | DATA_W | Stream beat data |
| m_tkeep_o | output | DATA_W/8 | Byte-keep mask |
| m_tlast_o | output | 1 | Final beat of the packet |

## Verification
The bench builds the block with a 32-bit data bus (4 byte lanes) and an 8-bit length. With four lanes, every residue class of the length, and so every legal final-beat mask, shows up within a few lengths. The bench sweeps every length from 1 to 20 under random source gaps and random sink stalls. It also runs the lengths at the top of the 8-bit range (252 to 255), where the round-up of the beat count would overflow the length width if it were not widened, and a zero-length command on its own and between packets.

// File: rtl/pktz_pkg.sv
package pktz_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } pktz_state_e;
endpackage

// File: rtl/pktz_keep.sv
module pktz_keep #(
  parameter int BYTES = 4,
  parameter int OFS_W = 2
) (
  input  logic [OFS_W-1:0] tail_i,
  input  logic             final_i,
  output logic [BYTES-1:0] keep_o
);
  logic full_tail;
  assign full_tail = (tail_i == '0);

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign keep_o[i] = !final_i || full_tail || (OFS_W'(i) < tail_i);
  end
endmodule

// File: rtl/pktz_ctrl.sv
module pktz_ctrl
  import pktz_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int BYTES = 4,
  parameter int OFS_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [LEN_W-1:0] cmd_len_i,
  input  logic             take_i,
  input  logic             done_i,
  output logic             cmd_ready_o,
  output logic             err_o,
  output logic             run_o,
  output logic             more_o,
  output logic             final_o,
  output logic [OFS_W-1:0] tail_o
);
  localparam int SHIFT = (BYTES > 1) ? $clog2(BYTES) : 0;

  pktz_state_e      state_q;
  logic [LEN_W-1:0] beats_q;
  logic [OFS_W-1:0] tail_q;
  logic             err_q;
  logic [LEN_W:0]   len_up;
  logic [LEN_W-1:0] beats_d;
  logic [OFS_W-1:0] tail_d;
  logic             accept;

  // widened so the round-up cannot wrap at the top of the length range
  assign len_up  = {1'b0, cmd_len_i} + (LEN_W+1)'(BYTES - 1);
  assign beats_d = LEN_W'(len_up >> SHIFT);

  if (BYTES > 1) begin : g_tail
    assign tail_d = cmd_len_i[OFS_W-1:0];
  end else begin : g_no_tail
    assign tail_d = '0;
  end

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign accept      = cmd_ready_o && cmd_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beats_q <= '0;
      tail_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= accept && (cmd_len_i == '0);
      case (state_q)
        ST_IDLE: begin
          if (accept && (cmd_len_i != '0)) begin
            state_q <= ST_RUN;
            beats_q <= beats_d;
            tail_q  <= tail_d;
          end
        end
        ST_RUN: begin
          if (take_i) beats_q <= beats_q - 1'b1;
          if (done_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign err_o   = err_q;
  assign run_o   = (state_q == ST_RUN);
  assign more_o  = run_o && (beats_q != '0);
  assign final_o = (beats_q == LEN_W'(1));
  assign tail_o  = tail_q;

  a_r1_take_within_budget: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> more_o);
  a_r8_err_keeps_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !run_o);
  a_r9_done_returns_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> cmd_ready_o);
endmodule

// File: rtl/pktz_out.sv
module pktz_out #(
  parameter int DATA_W = 32,
  parameter int BYTES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [BYTES-1:0]  keep_i,
  input  logic              last_i,
  input  logic              tready_i,
  output logic              tvalid_o,
  output logic [DATA_W-1:0] tdata_o,
  output logic [BYTES-1:0]  tkeep_o,
  output logic              tlast_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tvalid_o <= 1'b0;
      tdata_o  <= '0;
      tkeep_o  <= '0;
      tlast_o  <= 1'b0;
    end else begin
      if (load_i) begin
        tvalid_o <= 1'b1;
        tdata_o  <= data_i;
        tkeep_o  <= keep_i;
        tlast_o  <= last_i;
      end else if (tready_i) begin
        tvalid_o <= 1'b0;
      end
    end
  end

  a_r7_hold_under_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tvalid_o && !tready_i) |=> (tvalid_o && $stable(tdata_o) && $stable(tkeep_o) && $stable(tlast_o)));
  a_r3_full_keep_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tvalid_o && !tlast_o) |-> (tkeep_o == '1));
  a_r4_keep_contiguous: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tvalid_o |-> ((tkeep_o != '0) && ((tkeep_o & (tkeep_o + 1'b1)) == '0)));
endmodule

// File: rtl/stream_packetizer.sv
module stream_packetizer #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  output logic                cmd_ready_o,
  input  logic [LEN_W-1:0]    cmd_len_i,
  output logic                err_o,
  input  logic                src_valid_i,
  output logic                src_ready_o,
  input  logic [DATA_W-1:0]   src_data_i,
  output logic                m_tvalid_o,
  input  logic                m_tready_i,
  output logic [DATA_W-1:0]   m_tdata_o,
  output logic [DATA_W/8-1:0] m_tkeep_o,
  output logic                m_tlast_o
);
  localparam int BYTES = DATA_W / 8;
  localparam int OFS_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic             run, more, final_beat, take, done;
  logic [OFS_W-1:0] tail;
  logic [BYTES-1:0] keep;

  assign src_ready_o = more && (!m_tvalid_o || m_tready_i);
  assign take        = src_ready_o && src_valid_i;
  assign done        = m_tvalid_o && m_tready_i && m_tlast_o;

  pktz_ctrl #(.LEN_W(LEN_W), .BYTES(BYTES), .OFS_W(OFS_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_len_i   (cmd_len_i),
    .take_i      (take),
    .done_i      (done),
    .cmd_ready_o (cmd_ready_o),
    .err_o       (err_o),
    .run_o       (run),
    .more_o      (more),
    .final_o     (final_beat),
    .tail_o      (tail)
  );

  pktz_keep #(.BYTES(BYTES), .OFS_W(OFS_W)) u_keep (
    .tail_i  (tail),
    .final_i (final_beat),
    .keep_o  (keep)
  );

  pktz_out #(.DATA_W(DATA_W), .BYTES(BYTES)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (take),
    .data_i   (src_data_i),
    .keep_i   (keep),
    .last_i   (final_beat),
    .tready_i (m_tready_i),
    .tvalid_o (m_tvalid_o),
    .tdata_o  (m_tdata_o),
    .tkeep_o  (m_tkeep_o),
    .tlast_o  (m_tlast_o)
  );

  a_r6_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (!m_tvalid_o && !src_ready_o));
  a_r2_last_ends_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !m_tvalid_o);
endmodule

// File: tb/sim_stream_packetizer.sv
module sim_stream_packetizer;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 8;
  localparam int BYTES  = DATA_W / 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cmd_valid_i = 1'b0;
  logic              cmd_ready_o;
  logic [LEN_W-1:0]  cmd_len_i = '0;
  logic              err_o;
  logic              src_valid_i = 1'b0;
  logic              src_ready_o;
  logic [DATA_W-1:0] src_data_i = '0;
  logic              m_tvalid_o;
  logic              m_tready_i = 1'b0;
  logic [DATA_W-1:0] m_tdata_o;
  logic [BYTES-1:0]  m_tkeep_o;
  logic              m_tlast_o;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [DATA_W-1:0] src_word = 32'h1000_0000;
  logic [DATA_W-1:0] exp_word = 32'h1000_0000;

  always #10 clk = ~clk;

  stream_packetizer #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o), .cmd_len_i(cmd_len_i),
    .err_o(err_o),
    .src_valid_i(src_valid_i), .src_ready_o(src_ready_o), .src_data_i(src_data_i),
    .m_tvalid_o(m_tvalid_o), .m_tready_i(m_tready_i), .m_tdata_o(m_tdata_o),
    .m_tkeep_o(m_tkeep_o), .m_tlast_o(m_tlast_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [BYTES-1:0] last_keep(input int len);
    int r = len % BYTES;
    return (r == 0) ? '1 : BYTES'((1 << r) - 1);
  endfunction

  task automatic run_pkt(input int len);
    int exp_beats = (len + BYTES - 1) / BYTES;
    int beats = 0;
    int guard = 0;
    bit stall_prev = 0;
    bit first = 1;
    logic [DATA_W-1:0] d_prev = '0;
    logic [BYTES-1:0]  k_prev = '0;
    logic              l_prev = 1'b0;
    bit done = 0;
    @(negedge clk);
    cmd_len_i   = LEN_W'(len);
    cmd_valid_i = 1'b1;
    #5;
    check(cmd_ready_o === 1'b1, "R9 ready idle", cmd_ready_o, 1);
    while (!done && guard < 4000) begin
      guard++;
      @(negedge clk);
      cmd_valid_i = 1'b0;
      m_tready_i  = ($urandom_range(0, 3) != 0);
      src_valid_i = ($urandom_range(0, 3) != 0);
      src_data_i  = src_word;
      #5;
      if (first) begin
        check(cmd_ready_o === 1'b0, "R9 busy", cmd_ready_o, 0);
        first = 0;
      end
      if (stall_prev) begin
        check(m_tvalid_o === 1'b1 && m_tdata_o === d_prev && m_tkeep_o === k_prev
              && m_tlast_o === l_prev, "R7 hold", m_tdata_o, d_prev);
      end
      if (src_valid_i && src_ready_o) src_word++;
      if (m_tvalid_o && m_tready_i) begin
        beats++;
        check(m_tdata_o === exp_word, "R5 data", m_tdata_o, exp_word);
        exp_word++;
        if (beats == exp_beats) begin
          check(m_tlast_o === 1'b1, "R2 last", m_tlast_o, 1);
          check(m_tkeep_o === last_keep(len), "R4 tail keep", m_tkeep_o, last_keep(len));
          done = 1;
        end else begin
          check(m_tlast_o === 1'b0, "R2 not last", m_tlast_o, 0);
          check(m_tkeep_o === '1, "R3 full keep", m_tkeep_o, 4'hF);
        end
      end
      stall_prev = m_tvalid_o && !m_tready_i;
      d_prev = m_tdata_o; k_prev = m_tkeep_o; l_prev = m_tlast_o;
    end
    check(beats == exp_beats, "R1 R10 beat count", beats, exp_beats);
    @(negedge clk);
    src_valid_i = 1'b1;
    m_tready_i  = 1'b1;
    #5;
    check(m_tvalid_o === 1'b0 && src_ready_o === 1'b0, "R6 quiet after", m_tvalid_o, 0);
    check(cmd_ready_o === 1'b1, "R9 ready after", cmd_ready_o, 1);
  endtask

  task automatic zero_len();
    @(negedge clk);
    cmd_len_i = '0;
    cmd_valid_i = 1'b1;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    src_valid_i = 1'b1;
    m_tready_i  = 1'b1;
    #5;
    check(err_o === 1'b1, "R8 err pulse", err_o, 1);
    check(m_tvalid_o === 1'b0 && src_ready_o === 1'b0, "R8 no beat", m_tvalid_o, 0);
    @(negedge clk);
    #5;
    check(err_o === 1'b0, "R8 err one cycle", err_o, 0);
    check(cmd_ready_o === 1'b1 && m_tvalid_o === 1'b0, "R8 ready again", cmd_ready_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #5;
    check(cmd_ready_o === 1'b1 && m_tvalid_o === 1'b0 && err_o === 1'b0, "R9 reset state", m_tvalid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    src_valid_i = 1'b1;
    m_tready_i  = 1'b1;
    #5;
    check(m_tvalid_o === 1'b0 && src_ready_o === 1'b0, "R6 quiet before start", src_ready_o, 0);
    zero_len();
    for (int len = 1; len <= 20; len++) run_pkt(len);
    zero_len();
    for (int len = 252; len <= 255; len++) run_pkt(len);
    run_pkt(3);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=<200000", cycles);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule